// File: doc/BRIEF.md
# Timer Channel Start Trigger Register

This block is the start-control register of a four-channel timer unit. Firmware writes a 16-bit word through a small register bus. Each 1 in a trigger position arms the matching counter. The block then raises that counter's count-enable status bit and sends it a registered one-cycle start pulse. On that pulse the counter reloads and starts counting.

Channels 1 and 3 can each run as two 8-bit timers. In that mode the low-byte trigger for the channel starts its lower half. Two extra triggers in the high byte start the upper halves. A trigger never stays stored: it is consumed on the cycle its enable bit is raised, so the register always reads back as zero.

Each enable bit has its own stop-request input, which the counter side uses to drop the enable bit again. The enable bits leave the block on a separate read-only status output.

Top module: `tmr_start_ctrl`

## Requirements
- R1: While reset is held, and after it is released, `cnt_enable` and `start_pulse` are all zero.
- R2: A write cycle (`bus_sel`=1, `bus_wr`=1) that carries a 1 in data bit n (n=0..3) with `bus_be[0]`=1 sets `cnt_enable[n]` on the next clock edge after the write edge. A start pulse goes out on `start_pulse[n]` in that same cycle.
- R3: A 0 in a trigger position has no effect. The enable bit keeps its value and no pulse is issued.
- R4: With `bus_be[1]`=1, data bit 9 triggers the upper half of channel 1 through lane 4. Data bit 11 triggers the upper half of channel 3 through lane 5.
- R5: Data bits 15..12, 10 and 8..4 are reserved. Their values never trigger anything.
- R6: A low-byte-only write (`bus_be`=2'b01) triggers neither lane 4 nor lane 5, whatever bits 9 and 11 carry. A write with `bus_be[1]`=0 ignores the high byte.
- R7: Each accepted trigger produces exactly one start-pulse cycle, even when the enable bit is already 1. A trigger is consumed when the enable bit is raised and does not repeat.
- R8: A 1 on `stop_req[i]` clears `cnt_enable[i]` at the next edge. If the trigger for lane i takes effect on that same edge, that is, the stop is held in the cycle right after the write, the start wins and the bit ends up set.
- R9: `bus_rdata` is always zero.
- R10: The lane order of `stop_req`, `cnt_enable` and `start_pulse` is bit i = channel i for i=0..3, bit 4 = upper half of channel 1, and bit 5 = upper half of channel 3.
- R11: Writes on consecutive cycles give a start pulse on consecutive cycles, one for each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operating clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register selected in this cycle |
| bus_wr | input | 1 | Access is a write |
| bus_be | input | 2 | Byte strobes: bit 0 low byte, bit 1 high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, constant zero |
| stop_req | input | 6 | Per-lane request to clear the enable bit |
| cnt_enable | output | 6 | Count-enable status per lane |
| start_pulse | output | 6 | Registered one-cycle start pulse per lane |

## Verification
The assertions take some things for granted about the bus:
- A write is a single-cycle `bus_sel`/`bus_wr` strobe whose strobes and data are stable across the sampling edge.
- The stop requests are synchronous to `clk`.
- Firmware respects the pin-input settling wait before it triggers. That wait is not visible at these ports.

The stimulus keeps within these limits. It drives every bus and stop input on the falling edge and holds each for one whole cycle. It sweeps all 64 lane-bit combinations under every strobe pattern, with reserved bits set to a changing non-zero pattern. It adds directed sequences for the stop/start collision, for retriggering an enabled lane and for back-to-back writes.

// File: rtl/tmr_start_pkg.sv
package tmr_start_pkg;

  localparam int DATA_W   = 16;
  localparam int BYTE_W   = 8;
  localparam int NUM_BE   = DATA_W / BYTE_W;
  localparam int NUM_CH   = 4;
  // channels that can run as split 8-bit timers
  localparam logic [NUM_CH-1:0] SPLIT_CH = 4'b1010;

  function automatic int count_split();
    int n;
    n = 0;
    for (int c = 0; c < NUM_CH; c++) if (SPLIT_CH[c]) n++;
    return n;
  endfunction

  localparam int NUM_SPLIT = count_split();
  localparam int NUM_LANES = NUM_CH + NUM_SPLIT;

  // bit position of a lane's trigger inside the write word
  function automatic int lane_pos(int lane);
    int k;
    if (lane < NUM_CH) return lane;
    k = lane - NUM_CH;
    for (int c = 0; c < NUM_CH; c++) begin
      if (SPLIT_CH[c]) begin
        if (k == 0) return BYTE_W + c;
        k--;
      end
    end
    return 0;
  endfunction

  function automatic logic [DATA_W-1:0] trig_bits();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int l = 0; l < NUM_LANES; l++) m[lane_pos(l)] = 1'b1;
    return m;
  endfunction

  function automatic logic [NUM_LANES-1:0] high_lanes();
    logic [NUM_LANES-1:0] m;
    m = '0;
    for (int l = 0; l < NUM_LANES; l++) m[l] = (lane_pos(l) >= BYTE_W);
    return m;
  endfunction

  localparam logic [DATA_W-1:0]    TRIG_MASK = trig_bits();
  localparam logic [NUM_LANES-1:0] HI_LANES  = high_lanes();

endpackage

// File: rtl/tmr_reset_sync.sv
module tmr_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tmr_write_decode.sv
module tmr_write_decode
  import tmr_start_pkg::*;
#(
  parameter int LANES = NUM_LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [NUM_BE-1:0] bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  trig_set
);

  logic wr_hit;
  assign wr_hit = bus_sel & bus_wr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int POS  = lane_pos(g);
    localparam int BYTE = POS / BYTE_W;
    assign trig_set[g] = wr_hit & bus_be[BYTE] & bus_wdata[POS];
  end

  // R5: only reserved bits set -> nothing armed
  assert_reserved_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && ((bus_wdata & TRIG_MASK) == '0)) |-> (trig_set == '0));

  // R6: low-byte write never reaches the upper-half lanes
  assert_low_byte_spares_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && bus_be == 2'b01) |-> ((trig_set & HI_LANES) == '0));

  // R3: no write, no trigger
  assert_idle_no_trigger_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |-> (trig_set == '0));

endmodule

// File: rtl/tmr_trigger_stage.sv
module tmr_trigger_stage #(
  parameter int LANES = tmr_start_pkg::NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] trig_set,
  output logic [LANES-1:0] trig_q
);

  logic [LANES-1:0] trig_d;
  logic             trig_en;

  // a held trigger is consumed at the edge that raises its enable bit
  always_comb begin
    trig_d  = trig_set;
    trig_en = (|trig_set) | (|trig_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trig_q <= '0;
    else if (trig_en) trig_q <= trig_d;
  end

  // R7: a trigger lives one cycle unless rewritten
  assert_trigger_self_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|trig_q) && trig_set == '0) |=> (trig_q == '0));

endmodule

// File: rtl/tmr_enable_bank.sv
module tmr_enable_bank #(
  parameter int LANES = tmr_start_pkg::NUM_LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] trig_q,
  input  logic [LANES-1:0] stop_req,
  output logic [LANES-1:0] en_q,
  output logic [LANES-1:0] pulse_q
);

  for (genvar g = 0; g < LANES; g++) begin : g_bit
    logic en_d, en_ce, pulse_d, pulse_ce;

    always_comb begin
      // start beats stop
      en_d     = trig_q[g] | (en_q[g] & ~stop_req[g]);
      en_ce    = trig_q[g] | stop_req[g];
      pulse_d  = trig_q[g];
      pulse_ce = trig_q[g] | pulse_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q[g] <= 1'b0;
      else if (en_ce) en_q[g] <= en_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pulse_q[g] <= 1'b0;
      else if (pulse_ce) pulse_q[g] <= pulse_d;
    end

    assert_start_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      trig_q[g] |=> (en_q[g] && pulse_q[g]));

    assert_stop_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req[g] && !trig_q[g]) |=> (!en_q[g] && !pulse_q[g]));

    assert_rise_has_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[g]) |-> pulse_q[g]);

    assert_pulse_needs_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_q[g] |=> !pulse_q[g]);
  end

endmodule

// File: rtl/tmr_start_ctrl.sv
module tmr_start_ctrl
  import tmr_start_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [NUM_BE-1:0]    bus_be,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LANES-1:0] stop_req,
  output logic [NUM_LANES-1:0] cnt_enable,
  output logic [NUM_LANES-1:0] start_pulse
);

  logic                 rst_n_sync;
  logic [NUM_LANES-1:0] trig_set;
  logic [NUM_LANES-1:0] trig_q;

  tmr_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  tmr_write_decode #(.LANES(NUM_LANES)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .trig_set  (trig_set)
  );

  tmr_trigger_stage #(.LANES(NUM_LANES)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .trig_set (trig_set),
    .trig_q   (trig_q)
  );

  tmr_enable_bank #(.LANES(NUM_LANES)) u_en (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .trig_q   (trig_q),
    .stop_req (stop_req),
    .en_q     (cnt_enable),
    .pulse_q  (start_pulse)
  );

  // R9: trigger bits never read back
  assign bus_rdata = '0;

  // R1: nothing active while the released reset is still propagating
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_n_sync |=> (cnt_enable == '0 && start_pulse == '0));

  // R2: a pulse always leaves its enable bit set
  assert_pulse_implies_enable_R2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    |start_pulse |-> ((start_pulse & ~cnt_enable) == '0));

endmodule

// File: tb/test_tmr_start_ctrl.sv
module test_tmr_start_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_be;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [5:0]  stop_req;
  logic [5:0]  cnt_enable;
  logic [5:0]  start_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  logic [5:0] exp_en;

  always #5 clk = ~clk;

  tmr_start_ctrl i_tmr_start_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stop_req(stop_req), .cnt_enable(cnt_enable), .start_pulse(start_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] lanes_of(input logic [15:0] d, input logic [1:0] be);
    logic [5:0] m;
    m = '0;
    if (be[0]) m[3:0] = d[3:0];
    if (be[1]) m[5:4] = {d[11], d[9]};
    return m;
  endfunction

  function automatic logic [15:0] pack(input logic [5:0] l, input int salt);
    logic [15:0] r;
    r = (16'(salt) * 16'h3B71 + 16'hA5C0) & 16'hF5F0;
    r[3:0] = l[3:0];
    r[9]   = l[4];
    r[11]  = l[5];
    return r;
  endfunction

  task automatic bus_write(input logic [15:0] d, input logic [1:0] be);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0; bus_wdata = '0;
  endtask

  task automatic clear_all();
    stop_req = '1;
    @(negedge clk);
    stop_req = '0;
    exp_en = '0;
    chk(cnt_enable == 6'h0, "R8 stop clears", 16'(cnt_enable), 16'h0);
  endtask

  // full write sequence with checks
  task automatic write_and_check(input logic [15:0] d, input logic [1:0] be, input string tag);
    logic [5:0] m;
    m = lanes_of(d, be);
    bus_write(d, be);
    chk(bus_rdata == 16'h0, "R9 rdata zero", bus_rdata, 16'h0);
    chk(start_pulse == 6'h0, {tag, " no early pulse"}, 16'(start_pulse), 16'h0);
    @(negedge clk);
    exp_en = exp_en | m;
    chk(start_pulse == m, {tag, " pulse lanes"}, 16'(start_pulse), 16'(m));
    chk(cnt_enable == exp_en, {tag, " enable set"}, 16'(cnt_enable), 16'(exp_en));
    @(negedge clk);
    chk(start_pulse == 6'h0, "R7 single pulse", 16'(start_pulse), 16'h0);
    chk(cnt_enable == exp_en, "R7 enable held", 16'(cnt_enable), 16'(exp_en));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_be = '0; bus_wdata = '0; stop_req = '0;
    exp_en = '0;
    repeat (3) @(negedge clk);
    chk(cnt_enable == 0 && start_pulse == 0, "R1 in reset", {4'h0, cnt_enable, start_pulse}, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cnt_enable == 0 && start_pulse == 0, "R1 after reset", {4'h0, cnt_enable, start_pulse}, 16'h0);
    chk(bus_rdata == 16'h0, "R9 rdata at idle", bus_rdata, 16'h0);

    // sweep: every lane combination under every strobe pattern (R2 R4 R5 R6 R10)
    for (int l = 0; l < 64; l++) begin
      for (int b = 0; b < 4; b++) begin
        clear_all();
        write_and_check(pack(6'(l), l * 4 + b), 2'(b), "R2 R4 R5 R6 R10");
      end
    end

    // reserved bits only (R5)
    clear_all();
    write_and_check(16'hF5F0, 2'b11, "R5 reserved only");

    // R3: writing zeros keeps enables and gives no pulse
    clear_all();
    write_and_check(16'h0A05, 2'b11, "R3 setup");
    write_and_check(16'h0000, 2'b11, "R3 zero write");

    // R7: retrigger an already enabled lane
    write_and_check(16'h0001, 2'b01, "R7 retrigger");

    // R6: low byte alone leaves high lanes untouched
    clear_all();
    write_and_check(16'h0A00, 2'b01, "R6 low only");
    chk(cnt_enable[5:4] == 2'b00, "R6 high lanes idle", 16'(cnt_enable), 16'h0);

    // R8: stop and start collide on the same edge -> start wins
    clear_all();
    bus_write(16'h0001, 2'b01);
    stop_req = 6'h3F;
    @(negedge clk);
    stop_req = '0;
    chk(cnt_enable == 6'h01, "R8 start wins", 16'(cnt_enable), 16'h01);
    chk(start_pulse == 6'h01, "R8 pulse on collision", 16'(start_pulse), 16'h01);
    // single-lane stop leaves others
    bus_write(16'h0A02, 2'b11);
    @(negedge clk);
    stop_req = 6'h02;
    @(negedge clk);
    stop_req = '0;
    chk(cnt_enable == 6'h31, "R8 single stop", 16'(cnt_enable), 16'h31);

    // R11: back-to-back writes pulse on consecutive cycles
    clear_all();
    bus_sel = 1; bus_wr = 1; bus_be = 2'b01; bus_wdata = 16'h0004;
    @(negedge clk);
    bus_wdata = 16'h0004;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_be = '0; bus_wdata = '0;
    chk(start_pulse == 6'h04, "R11 first pulse", 16'(start_pulse), 16'h04);
    @(negedge clk);
    chk(start_pulse == 6'h04, "R11 second pulse", 16'(start_pulse), 16'h04);
    @(negedge clk);
    chk(start_pulse == 6'h00, "R11 pulses end", 16'(start_pulse), 16'h00);
    chk(cnt_enable == 6'h04, "R11 enable", 16'(cnt_enable), 16'h04);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule